// File: doc/BRIEF.md
# Asynchronous SRAM Byte-Lane Controller

This block is a synchronous front-end for an external asynchronous static RAM. The RAM has an 18-bit address, a 16-bit data bus split into two 8-bit byte lanes, and one active-low enable per lane. The request side takes one word per valid/ready handshake, with address, write flag, a 2-bit byte-enable and write data. Reads return data with a one-cycle valid pulse. The memory side drives two chip selects of opposite polarity, output enable, write enable, the two lane enables and the address. The bidirectional data bus is split into separate out, in and drive-enable signals.

Every timing window is a clock-count parameter, rounded up from the nanosecond figure and the clock period. The read strobe time must cover address access. The write pulse must cover the longest of strobe width, select-to-end and address-to-end. A turnaround count must cover the output float time after a read. All strobes come straight from flops. Request fields are registered when the request is accepted and held until the cycle ends. A write always ends on the write strobe, with the select still asserted for one more cycle, so the data bus has hold time.

Top module: `sram_lane_ctrl`

## Requirements
- R1: Out of reset, and whenever ready is high, the memory pins are idle: the low-true select is high, the high-true select is low, output enable and write enable are high, both lane enables are high and the data drivers are off.
- R2: Ready drops on the edge that accepts a request and stays low until that access finishes. No second request is taken during an access.
- R3: A read asserts both selects and output enable for exactly RD_CYC cycles. The data bus is sampled on the edge that ends that window. The response valid signal then pulses high for one cycle.
- R4: Byte-enable bit 0 enables the low lane (data bits 7:0, lower enable low) and bit 1 enables the high lane (bits 15:8, upper enable low). In read data, a lane that was not enabled reads as zero.
- R5: A write holds write enable low for exactly WR_CYC cycles. Output enable stays high throughout, and the data drivers carry the write word.
- R6: A write ends on write enable rising while both selects are still asserted. The selects, lane enables and data drivers are held for one more cycle before going idle.
- R7: The data drivers are never on while output enable is low.
- R8: The data drivers are not switched on until at least TURN_CYC cycles after output enable rose at the end of a read. A write that arrives sooner waits with the pins idle.
- R9: Address, byte-enable, write flag and write data are registered when the request is accepted. Later changes on the request inputs do not affect the access in progress.
- R10: A request with both byte-enable bits zero leaves the pins idle. It completes after one cycle, and if it is a read its response carries zero data. A write of this kind leaves memory unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Controller idle, request accepted when valid |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | ADDR_W | Word address |
| req_be_i | input | 2 | Lane enables, bit 0 low byte, bit 1 high byte |
| req_wdata_i | input | DATA_W | Write data |
| rsp_valid_o | output | 1 | Read data valid pulse |
| rsp_rdata_o | output | DATA_W | Read data, disabled lanes zero |
| mem_cs_n_o | output | 1 | Chip select, active low |
| mem_cs_o | output | 1 | Chip select, active high |
| mem_oe_n_o | output | 1 | Output enable, active low |
| mem_we_n_o | output | 1 | Write enable, active low |
| mem_ub_n_o | output | 1 | Upper lane enable, active low |
| mem_lb_n_o | output | 1 | Lower lane enable, active low |
| mem_addr_o | output | ADDR_W | Memory address |
| mem_dq_o | output | DATA_W | Data bus out value |
| mem_dq_oe_o | output | 1 | Data bus drive enable |
| mem_dq_i | input | DATA_W | Data bus in value |

## Verification
A stuck or miscounted window counter shows up at once as a strobe of the wrong width. The output enable or write enable low time then differs from RD_CYC or WR_CYC, and that is visible at the ports on the very access where the fault occurs. A turnaround counter that is loaded wrongly lets the drivers switch on too soon after a read, and the first write issued straight after a read shows it. A faulty request latch or lane decode corrupts the model memory, and a fault in the response mask shows up on the next read-back as a wrong word or wrong lanes.

// File: rtl/sram_lane_pkg.sv
package sram_lane_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD,
    ST_WWAIT,
    ST_WR,
    ST_WHOLD,
    ST_NULL
  } seq_state_e;

  typedef struct packed {
    logic cs_n;
    logic cs;
    logic oe_n;
    logic we_n;
    logic ub_n;
    logic lb_n;
    logic dq_oe;
  } pin_ctl_t;

  localparam pin_ctl_t PINS_IDLE = '{cs_n: 1'b1, cs: 1'b0, oe_n: 1'b1, we_n: 1'b1,
                                     ub_n: 1'b1, lb_n: 1'b1, dq_oe: 1'b0};

endpackage

// File: rtl/sram_req_latch.sv
module sram_req_latch #(
  parameter int ADDR_W = 18,
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              accept_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [1:0]        be_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              we_o,
  output logic [1:0]        be_o,
  output logic [DATA_W-1:0] wdata_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_o  <= '0;
      we_o    <= 1'b0;
      be_o    <= '0;
      wdata_o <= '0;
    end else if (accept_i) begin
      addr_o  <= addr_i;
      we_o    <= we_i;
      be_o    <= be_i;
      wdata_o <= wdata_i;
    end
  end

endmodule

// File: rtl/sram_seq_fsm.sv
module sram_seq_fsm
  import sram_lane_pkg::*;
#(
  parameter int RD_CYC   = 9,  // >= 1
  parameter int WR_CYC   = 8,  // >= 1
  parameter int TURN_CYC = 4
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     req_valid_i,
  input  logic     req_we_i,
  input  logic [1:0] req_be_i,
  input  logic [1:0] be_q_i,
  input  logic     we_q_i,
  output logic     ready_o,
  output logic     accept_o,
  output pin_ctl_t pins_nxt_o,
  output logic     capture_o,
  output logic     null_rd_o
);

  localparam int MAXC   = (RD_CYC > WR_CYC) ? RD_CYC : WR_CYC;
  localparam int CNT_W  = $clog2(MAXC + 1);
  localparam int TURN_W = $clog2(TURN_CYC + 2);
  localparam logic [CNT_W-1:0]  RD_LAST = CNT_W'(RD_CYC - 1);
  localparam logic [CNT_W-1:0]  WR_LAST = CNT_W'(WR_CYC - 1);
  localparam logic [TURN_W-1:0] TURN_LD = TURN_W'(TURN_CYC);

  seq_state_e        st_q, st_n;
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic [TURN_W-1:0] turn_q;
  logic [1:0]        be_use;
  logic              turn_clear;

  assign ready_o    = (st_q == ST_IDLE);
  assign accept_o   = req_valid_i && ready_o;
  assign turn_clear = (turn_q == '0);
  assign null_rd_o  = (st_q == ST_NULL) && !we_q_i;

  always_comb begin
    st_n      = st_q;
    cnt_n     = cnt_q;
    capture_o = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (accept_o) begin
          cnt_n = '0;
          if (req_be_i == 2'b00)  st_n = ST_NULL;
          else if (req_we_i)      st_n = turn_clear ? ST_WR : ST_WWAIT;
          else                    st_n = ST_RD;
        end
      end
      ST_RD: begin
        if (cnt_q == RD_LAST) begin
          st_n      = ST_IDLE;
          capture_o = 1'b1;
        end else begin
          cnt_n = cnt_q + 1'b1;
        end
      end
      ST_WWAIT: if (turn_clear) st_n = ST_WR;
      ST_WR: begin
        if (cnt_q == WR_LAST) st_n = ST_WHOLD;
        else                  cnt_n = cnt_q + 1'b1;
      end
      ST_WHOLD: st_n = ST_IDLE;
      ST_NULL:  st_n = ST_IDLE;
      default:  st_n = ST_IDLE;
    endcase
  end

  // lane enables follow the live request on the accepting edge, the latch after
  always_comb begin
    be_use     = (st_q == ST_IDLE) ? req_be_i : be_q_i;
    pins_nxt_o = PINS_IDLE;
    unique case (st_n)
      ST_RD: begin
        pins_nxt_o.cs_n = 1'b0;
        pins_nxt_o.cs   = 1'b1;
        pins_nxt_o.oe_n = 1'b0;
        pins_nxt_o.lb_n = ~be_use[0];
        pins_nxt_o.ub_n = ~be_use[1];
      end
      ST_WR, ST_WHOLD: begin
        pins_nxt_o.cs_n  = 1'b0;
        pins_nxt_o.cs    = 1'b1;
        pins_nxt_o.we_n  = (st_n == ST_WHOLD);
        pins_nxt_o.lb_n  = ~be_use[0];
        pins_nxt_o.ub_n  = ~be_use[1];
        pins_nxt_o.dq_oe = 1'b1;
      end
      default: pins_nxt_o = PINS_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      turn_q <= '0;
    end else begin
      st_q  <= st_n;
      cnt_q <= cnt_n;
      if (capture_o)        turn_q <= TURN_LD;
      else if (!turn_clear) turn_q <= turn_q - 1'b1;
    end
  end

  // R2: ready stays low through the access once a request is taken
  assert_busy_after_accept_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept_o && req_be_i != 2'b00) |=> !ready_o);

endmodule

// File: rtl/sram_pin_drv.sv
module sram_pin_drv
  import sram_lane_pkg::*;
#(
  parameter int RD_CYC   = 9,
  parameter int WR_CYC   = 8,
  parameter int TURN_CYC = 4
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  pin_ctl_t pins_nxt_i,
  output logic     cs_n_o,
  output logic     cs_o,
  output logic     oe_n_o,
  output logic     we_n_o,
  output logic     ub_n_o,
  output logic     lb_n_o,
  output logic     dq_oe_o
);

  pin_ctl_t pins_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pins_q <= PINS_IDLE;
    else         pins_q <= pins_nxt_i;
  end

  assign cs_n_o  = pins_q.cs_n;
  assign cs_o    = pins_q.cs;
  assign oe_n_o  = pins_q.oe_n;
  assign we_n_o  = pins_q.we_n;
  assign ub_n_o  = pins_q.ub_n;
  assign lb_n_o  = pins_q.lb_n;
  assign dq_oe_o = pins_q.dq_oe;

  // strobe-width and gap monitors for the checks below
  localparam int MAXW = ((RD_CYC > WR_CYC) ? RD_CYC : WR_CYC) + TURN_CYC + 1;
  localparam int MW   = $clog2(MAXW + 1);

  logic [MW-1:0] oe_low_q, we_low_q, gap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      oe_low_q <= '0;
      we_low_q <= '0;
      gap_q    <= MW'(TURN_CYC);
    end else begin
      oe_low_q <= !oe_n_o ? ((oe_low_q == MW'(MAXW)) ? oe_low_q : oe_low_q + 1'b1) : '0;
      we_low_q <= !we_n_o ? ((we_low_q == MW'(MAXW)) ? we_low_q : we_low_q + 1'b1) : '0;
      if (!oe_n_o)                     gap_q <= '0;
      else if (gap_q < MW'(TURN_CYC))  gap_q <= gap_q + 1'b1;
    end
  end

  assert_rd_width_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(oe_n_o) |-> (oe_low_q == MW'(RD_CYC)));

  assert_wr_width_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_n_o |-> (oe_n_o && dq_oe_o && !cs_n_o && cs_o));

  assert_wr_len_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(we_n_o) |-> (we_low_q == MW'(WR_CYC)));

  assert_we_ends_first_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(we_n_o) |-> (!cs_n_o && cs_o && dq_oe_o));

  assert_no_contention_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dq_oe_o |-> oe_n_o);

  assert_turn_gap_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dq_oe_o) |-> (gap_q >= MW'(TURN_CYC)));

endmodule

// File: rtl/sram_rd_capture.sv
module sram_rd_capture #(
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              capture_i,
  input  logic              null_rd_i,
  input  logic [1:0]        be_i,
  input  logic [DATA_W-1:0] dq_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] rdata_o
);

  localparam int LANE_W = DATA_W / 2;

  logic [DATA_W-1:0] masked;

  for (genvar g = 0; g < 2; g++) begin : g_lane
    assign masked[g*LANE_W +: LANE_W] = be_i[g] ? dq_i[g*LANE_W +: LANE_W] : '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      rdata_o <= '0;
    end else begin
      valid_o <= capture_i || null_rd_i;
      if (capture_i)      rdata_o <= masked;
      else if (null_rd_i) rdata_o <= '0;
    end
  end

endmodule

// File: rtl/sram_lane_ctrl.sv
module sram_lane_ctrl
  import sram_lane_pkg::*;
#(
  parameter int ADDR_W   = 18,
  parameter int DATA_W   = 16,
  parameter int RD_CYC   = 9,
  parameter int WR_CYC   = 8,
  parameter int TURN_CYC = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_we_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [1:0]        req_be_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              rsp_valid_o,
  output logic [DATA_W-1:0] rsp_rdata_o,
  output logic              mem_cs_n_o,
  output logic              mem_cs_o,
  output logic              mem_oe_n_o,
  output logic              mem_we_n_o,
  output logic              mem_ub_n_o,
  output logic              mem_lb_n_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              mem_dq_oe_o,
  input  logic [DATA_W-1:0] mem_dq_i
);

  logic              accept, capture, null_rd, we_q;
  logic [1:0]        be_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  pin_ctl_t          pins_nxt;

  sram_req_latch #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_latch (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .accept_i (accept),
    .addr_i   (req_addr_i),
    .we_i     (req_we_i),
    .be_i     (req_be_i),
    .wdata_i  (req_wdata_i),
    .addr_o   (addr_q),
    .we_o     (we_q),
    .be_o     (be_q),
    .wdata_o  (wdata_q)
  );

  sram_seq_fsm #(.RD_CYC(RD_CYC), .WR_CYC(WR_CYC), .TURN_CYC(TURN_CYC)) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid_i),
    .req_we_i    (req_we_i),
    .req_be_i    (req_be_i),
    .be_q_i      (be_q),
    .we_q_i      (we_q),
    .ready_o     (req_ready_o),
    .accept_o    (accept),
    .pins_nxt_o  (pins_nxt),
    .capture_o   (capture),
    .null_rd_o   (null_rd)
  );

  sram_pin_drv #(.RD_CYC(RD_CYC), .WR_CYC(WR_CYC), .TURN_CYC(TURN_CYC)) u_pins (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pins_nxt_i (pins_nxt),
    .cs_n_o     (mem_cs_n_o),
    .cs_o       (mem_cs_o),
    .oe_n_o     (mem_oe_n_o),
    .we_n_o     (mem_we_n_o),
    .ub_n_o     (mem_ub_n_o),
    .lb_n_o     (mem_lb_n_o),
    .dq_oe_o    (mem_dq_oe_o)
  );

  sram_rd_capture #(.DATA_W(DATA_W)) u_rd (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .capture_i (capture),
    .null_rd_i (null_rd),
    .be_i      (be_q),
    .dq_i      (mem_dq_i),
    .valid_o   (rsp_valid_o),
    .rdata_o   (rsp_rdata_o)
  );

  assign mem_addr_o = addr_q;
  assign mem_dq_o   = wdata_q;

  assert_idle_pins_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> (mem_cs_n_o && !mem_cs_o && mem_oe_n_o && mem_we_n_o &&
                     mem_ub_n_o && mem_lb_n_o && !mem_dq_oe_o));

  assert_fields_held_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_ready_o |=> ($stable(mem_addr_o) && $stable(mem_dq_o)));

  assert_null_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && req_be_i == 2'b00) |=> (mem_cs_n_o && mem_oe_n_o && mem_we_n_o));

endmodule

// File: tb/sram_lane_ctrl_tb.sv
`timescale 1ns/1ps
module sram_lane_ctrl_tb;

  localparam int ADDR_W = 18, DATA_W = 16, RD_CYC = 9, WR_CYC = 8, TURN_CYC = 4;

  logic              clk = 1'b0, rst_ni = 1'b0;
  logic              req_valid = 1'b0, req_we = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [1:0]        req_be = '0;
  logic [DATA_W-1:0] req_wdata = '0;
  logic              req_ready, rsp_valid;
  logic [DATA_W-1:0] rsp_rdata, dq_o, dq_i;
  logic              cs_n, cs, oe_n, we_n, ub_n, lb_n, dq_oe;
  logic [ADDR_W-1:0] maddr;

  int tests = 0, fails = 0, cyc = 0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  sram_lane_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .RD_CYC(RD_CYC),
                   .WR_CYC(WR_CYC), .TURN_CYC(TURN_CYC)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_we_i(req_we), .req_addr_i(req_addr), .req_be_i(req_be), .req_wdata_i(req_wdata),
    .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata), .mem_cs_n_o(cs_n), .mem_cs_o(cs),
    .mem_oe_n_o(oe_n), .mem_we_n_o(we_n), .mem_ub_n_o(ub_n), .mem_lb_n_o(lb_n),
    .mem_addr_o(maddr), .mem_dq_o(dq_o), .mem_dq_oe_o(dq_oe), .mem_dq_i(dq_i));

  // external RAM model
  logic [15:0] mem [256];
  logic        sel;
  assign sel  = !cs_n && cs;
  assign dq_i = (sel && !oe_n && we_n) ?
                {ub_n ? 8'hA5 : mem[maddr[7:0]][15:8], lb_n ? 8'h5A : mem[maddr[7:0]][7:0]} :
                16'hC3C3;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  logic       pend = 1'b0, p_ub, p_lb, prev_oe_n = 1'b1, prev_dq_oe = 1'b0, seen_rise = 1'b0;
  logic [7:0] p_idx;
  logic [15:0] p_dat;
  int         oe_rise_cyc = 0;

  always @(negedge clk) begin
    if (rst_ni) begin
      if (sel && !we_n) begin
        pend = 1'b1; p_idx = maddr[7:0]; p_ub = ub_n; p_lb = lb_n;
        p_dat = dq_oe ? dq_o : 16'hxxxx;
      end else if (pend && we_n) begin
        pend = 1'b0;
        if (!p_lb) mem[p_idx][7:0]  = p_dat[7:0];
        if (!p_ub) mem[p_idx][15:8] = p_dat[15:8];
      end
      if (dq_oe) chk(oe_n, "R7 drivers on with output enable low", {31'd0, oe_n}, 1);
      if (!prev_oe_n && oe_n) begin oe_rise_cyc = cyc; seen_rise = 1'b1; end
      if (!prev_dq_oe && dq_oe && seen_rise)
        chk(cyc - oe_rise_cyc >= TURN_CYC, "R8 turnaround gap", cyc - oe_rise_cyc, TURN_CYC);
      prev_oe_n  = oe_n;
      prev_dq_oe = dq_oe;
    end
  end

  task automatic chk_idle(input string req);
    chk(req_ready && cs_n && !cs && oe_n && we_n && ub_n && lb_n && !dq_oe, req,
        {25'd0, req_ready, cs_n, cs, oe_n, we_n, ub_n, lb_n}, 7'b1101111);
  endtask

  // begins and ends right after a negedge
  task automatic t_write(input logic [7:0] a, input logic [1:0] be, input logic [15:0] d,
                         output int waited);
    int lowc = 0;
    waited = 0;
    req_valid = 1'b1; req_we = 1'b1; req_addr = ADDR_W'(a); req_be = be; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_addr = ~req_addr; req_wdata = ~d; req_be = ~be;
    chk(!req_ready, "R2 ready low after write accept", req_ready, 0);
    while (we_n && waited < 50) begin
      chk(cs_n && !dq_oe, "R8 pins idle while waiting", {cs_n, dq_oe}, 2'b10);
      waited++; @(negedge clk);
    end
    while (!we_n && lowc < 50) begin
      chk(oe_n && dq_oe && dq_o == d, "R5 write strobe state", dq_o, d);
      chk(maddr == ADDR_W'(a) && lb_n == !be[0] && ub_n == !be[1], "R9 held addr/lanes",
          maddr, ADDR_W'(a));
      lowc++; @(negedge clk);
    end
    chk(lowc == WR_CYC, "R5 write strobe width", lowc, WR_CYC);
    chk(!cs_n && cs && we_n && dq_oe, "R6 hold cycle after write end", {cs_n, cs, dq_oe}, 3'b011);
    @(negedge clk);
    chk_idle("R1 idle after write");
  endtask

  task automatic t_read(input logic [7:0] a, input logic [1:0] be, input logic [15:0] exp);
    int lowc = 0;
    req_valid = 1'b1; req_we = 1'b0; req_addr = ADDR_W'(a); req_be = be; req_wdata = 16'h0;
    @(negedge clk);
    req_valid = 1'b0; req_addr = ~req_addr; req_be = ~be;
    chk(!req_ready, "R2 ready low after read accept", req_ready, 0);
    while (!oe_n && lowc < 50) begin
      chk(sel && we_n && lb_n == !be[0] && ub_n == !be[1], "R4 read lane enables",
          {lb_n, ub_n}, {!be[0], !be[1]});
      chk(!rsp_valid, "R3 no early response", rsp_valid, 0);
      lowc++; @(negedge clk);
    end
    chk(lowc == RD_CYC, "R3 read strobe width", lowc, RD_CYC);
    chk(rsp_valid, "R3 response valid", rsp_valid, 1);
    chk(rsp_rdata == exp, "R4 read data lanes", rsp_rdata, exp);
    chk_idle("R1 idle after read");
    @(negedge clk);
    chk(!rsp_valid, "R3 response is a single pulse", rsp_valid, 0);
  endtask

  task automatic t_null(input logic we, input logic [7:0] a);
    req_valid = 1'b1; req_we = we; req_addr = ADDR_W'(a); req_be = 2'b00; req_wdata = 16'hFFFF;
    @(negedge clk);
    req_valid = 1'b0;
    chk(!req_ready && cs_n && !cs && oe_n && we_n && !dq_oe, "R10 null keeps pins idle",
        {req_ready, cs_n, oe_n, we_n}, 4'b0111);
    @(negedge clk);
    chk(req_ready && rsp_valid == !we, "R10 null completes", {req_ready, rsp_valid}, {1'b1, !we});
    if (!we) chk(rsp_rdata == 16'h0, "R10 null read data zero", rsp_rdata, 0);
    @(negedge clk);
  endtask

  initial begin
    int w;
    for (int i = 0; i < 256; i++) mem[i] = 16'h0;
    repeat (3) @(negedge clk);
    chk_idle("R1 pins during reset");
    rst_ni = 1'b1;
    @(negedge clk);
    chk_idle("R1 pins after reset");
    chk(!rsp_valid, "R1 no response after reset", rsp_valid, 0);

    t_write(8'h10, 2'b11, 16'h1234, w);
    t_read (8'h10, 2'b11, 16'h1234);
    t_write(8'h10, 2'b01, 16'hABFF, w);
    t_read (8'h10, 2'b11, 16'h12FF);
    t_read (8'h10, 2'b01, 16'h00FF);
    t_read (8'h10, 2'b10, 16'h1200);
    t_write(8'h22, 2'b10, 16'h77EE, w);
    t_read (8'h22, 2'b11, 16'h7700);

    // R8: write right behind a read must wait out the turnaround
    t_read (8'h22, 2'b11, 16'h7700);
    t_write(8'h33, 2'b11, 16'hC0DE, w);
    chk(w > 0, "R8 write held back after read", w, 1);
    t_read (8'h33, 2'b11, 16'hC0DE);

    t_null(1'b0, 8'h33);
    t_null(1'b1, 8'h10);
    t_read (8'h10, 2'b11, 16'h12FF);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #800000;
    tests++; fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule